// File: doc/BRIEF.md
# Quad Read Wrap and Continuous-Mode Sequencer

This block is the addressing and sequencing core of an execute-in-place flash target that serves quad I/O reads. It watches a nibble stream qualified by a strobe and an active-low select. For every selection it reports which phase of the command it is in and presents the byte address the read is at. It decodes three quad read variants: fast quad read (EBh), word quad read (E7h) and octal-word quad read (E3h). It also decodes the set-burst-with-wrap command (77h), which loads a wrap setting. Driving the IO pads and the storage array are left to neighbouring logic, which reads the phase and byte address outputs.

When wrap is enabled, fast and word reads run round an aligned window of 8, 16, 32 or 64 bytes inside a 256-byte page. When wrap is disabled, and for octal-word reads in every case, the address climbs linearly. The mode byte that follows the address can put the target into continuous read mode. In that mode the next selection skips the opcode and starts at the address, reusing the previous read variant. Each nibble strobe stands for one serial clock. An opcode takes eight strobes, one bit per strobe on the lowest nibble line.

Top module: `qrs_top`

## Requirements
- R1: While `cs_n` is high, strobes have no effect, and `phase` is 0 (idle) one cycle after any cycle in which `cs_n` was high. `byte_addr` keeps its value.
- R2: A normal selection starts in phase 1 (instruction) and takes eight strobes, MSB first, with the opcode bit on `nib[0]`. Opcodes EBh, E7h, E3h and 77h are decoded. Any other opcode puts the block in phase 6 (hold) until deselection.
- R3: After a read opcode the phase is 2 (address). Six nibbles, most significant first, form a 24-bit address. After the sixth nibble, `byte_addr` shows that address and the phase becomes 3 (mode).
- R4: The mode byte takes two strobes. The dummy phase (4) follows and lasts 4 strobes for EBh, 2 strobes for E7h and none for E3h. The data phase (5) comes after it.
- R5: In the data phase, every second strobe completes a byte and advances `byte_addr` by one. Without wrap the address rolls over from FFFFFFh to 000000h.
- R6: An E7h read forces address bit 0 to 0. An E3h read forces address bits 3..0 to 0.
- R7: A 77h command has 6 dummy strobes (phase 4), then a 2-nibble wrap byte (phase 5), then phase 6. In the wrap byte, bit 4 = 0 enables wrap and bit 4 = 1 disables it. Bits 6..5 select the length: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bytes.
- R8: With wrap enabled, an EBh or E7h read advances only the low log2(length) bits of the address, modulo the length, and the upper bits stay fixed. E3h reads always advance linearly.
- R9: After reset the phase is 0, `byte_addr` is 0, wrap is disabled and continuous mode is off.
- R10: If bits 1..0 of the first mode nibble (mode bits 5..4) are 10b, the next selection starts in phase 2 and reuses the previous read variant. Any other value makes the next selection start in phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low target select |
| nib_vld | input | 1 | Strobe: one serial clock worth of nibble data |
| nib | input | 4 | Nibble on the four data lines |
| phase | output | 3 | 0 idle, 1 instruction, 2 address, 3 mode, 4 dummy, 5 data, 6 hold |
| byte_addr | output | 24 | Current byte address of the read |

## Verification
Linear reads that run across the top of the address space show whether the incrementer rolls over cleanly. Wrapped reads that start near the end of a window, at each of the four lengths, tell a modulo increment apart from a plain carry into the upper bits. Octal-word reads with wrap switched on show that wrap is applied only to the right variants. Odd and unaligned start addresses separate the word and octal alignment rules. Mode bytes with and without the 10b pattern show whether the opcode phase is skipped on the next selection. Random runs mix all of these with random addresses and lengths, and add strobes sent while deselected.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INSTR = 3'd1,
    PH_ADDR  = 3'd2,
    PH_MODE  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_DATA  = 3'd5,
    PH_HOLD  = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    RV_FAST    = 2'd0,
    RV_WORD    = 2'd1,
    RV_OCTAL   = 2'd2,
    RV_WRAPSET = 2'd3
  } rvar_e;

  localparam logic [7:0] OPC_FAST    = 8'hEB;
  localparam logic [7:0] OPC_WORD    = 8'hE7;
  localparam logic [7:0] OPC_OCTAL   = 8'hE3;
  localparam logic [7:0] OPC_WRAPSET = 8'h77;

endpackage

// File: rtl/qrs_wrap_cfg.sv
module qrs_wrap_cfg #(
  parameter int PAGE_W      = 8,
  parameter int MIN_WRAP_LG = 3,
  parameter int SEL_W       = 2,
  parameter int SEL_LSB     = 5,
  parameter int EN_BIT      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_byte,
  output logic              wrap_en,
  output logic [PAGE_W-1:0] wrap_mask
);

  localparam int NSIZE = 1 << SEL_W;

  logic [PAGE_W-1:0] mask_tbl [NSIZE];
  logic [SEL_W-1:0]  sel;

  // one mask per selectable window length
  for (genvar k = 0; k < NSIZE; k++) begin : g_mask
    assign mask_tbl[k] = PAGE_W'((1 << (MIN_WRAP_LG + k)) - 1);
  end

  assign sel = cfg_byte[SEL_LSB +: SEL_W];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_en   <= 1'b0;
      wrap_mask <= mask_tbl[0];
    end else if (cfg_we) begin
      wrap_en   <= ~cfg_byte[EN_BIT];
      wrap_mask <= mask_tbl[sel];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(wrap_en) && $stable(wrap_mask)); // R7

endmodule

// File: rtl/qrs_addr_gen.sv
module qrs_addr_gen
  import qrs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_W     = 8,
  parameter int WORD_LSBS  = 1,
  parameter int OCTAL_LSBS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        nib,
  input  logic              addr_shift,
  input  logic              addr_load,
  input  logic              byte_step,
  input  rvar_e             variant,
  input  logic              wrap_en,
  input  logic [PAGE_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] byte_addr
);

  localparam int SH_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] WORD_KEEP  = ~ADDR_W'((1 << WORD_LSBS) - 1);
  localparam logic [ADDR_W-1:0] OCTAL_KEEP = ~ADDR_W'((1 << OCTAL_LSBS) - 1);

  logic [SH_W-1:0]   sh_q;
  logic [ADDR_W-1:0] full_addr;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] next_addr;
  logic              wrap_act;

  assign full_addr = {sh_q, nib};

  always_comb begin
    case (variant)
      RV_WORD:  aligned = full_addr & WORD_KEEP;
      RV_OCTAL: aligned = full_addr & OCTAL_KEEP;
      default:  aligned = full_addr;
    endcase
  end

  assign win_mask  = {{(ADDR_W-PAGE_W){1'b0}}, wrap_mask};
  assign wrap_act  = wrap_en && (variant == RV_FAST || variant == RV_WORD);
  assign incr      = byte_addr + ADDR_W'(1);
  assign next_addr = wrap_act ? ((byte_addr & ~win_mask) | (incr & win_mask)) : incr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      byte_addr <= '0;
    end else begin
      if (addr_shift) sh_q <= full_addr[SH_W-1:0];
      if (addr_load)      byte_addr <= aligned;
      else if (byte_step) byte_addr <= next_addr;
    end
  end

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (addr_load && variant == RV_WORD) |=> byte_addr[0] == 1'b0); // R6

  AST_OCTAL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (addr_load && variant == RV_OCTAL) |=> byte_addr[3:0] == 4'h0); // R6

  AST_WRAP_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (byte_step && wrap_act) |=>
      ((byte_addr & ~$past(win_mask)) == ($past(byte_addr) & ~$past(win_mask)))); // R8

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!addr_load && !byte_step) |=> $stable(byte_addr)); // R1

endmodule

// File: rtl/qrs_ctrl.sv
module qrs_ctrl
  import qrs_pkg::*;
#(
  parameter int OP_BITS     = 8,
  parameter int ADDR_NIBS   = 6,
  parameter int FAST_DUMMY  = 4,
  parameter int WORD_DUMMY  = 2,
  parameter int OCTAL_DUMMY = 0,
  parameter int SETUP_DUMMY = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       nib_vld,
  input  logic [3:0] nib,
  output phase_e     phase_o,
  output rvar_e      variant_o,
  output logic       addr_shift,
  output logic       addr_load,
  output logic       byte_step,
  output logic       cfg_we,
  output logic [7:0] cfg_byte
);

  localparam int MAX_A = (OP_BITS > ADDR_NIBS) ? OP_BITS : ADDR_NIBS;
  localparam int MAX_B = (FAST_DUMMY > SETUP_DUMMY) ? FAST_DUMMY : SETUP_DUMMY;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  phase_e           phase_q, phase_d, eff_ph, start_ph;
  rvar_e            var_q, var_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, dlen;
  logic [OP_BITS-2:0] op_q, op_d;
  logic [OP_BITS-1:0] opcode;
  logic [3:0]       hi_q, hi_d;
  logic             cont_q, cont_d;
  logic             take;

  always_comb begin
    case (var_q)
      RV_FAST:  dlen = CNT_W'(FAST_DUMMY);
      RV_WORD:  dlen = CNT_W'(WORD_DUMMY);
      RV_OCTAL: dlen = CNT_W'(OCTAL_DUMMY);
      default:  dlen = CNT_W'(SETUP_DUMMY);
    endcase
  end

  assign start_ph = cont_q ? PH_ADDR : PH_INSTR;
  assign eff_ph   = (phase_q == PH_IDLE) ? start_ph : phase_q;
  assign take     = nib_vld && !cs_n;
  assign opcode   = {op_q, nib[0]};

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    op_d       = op_q;
    hi_d       = hi_q;
    var_d      = var_q;
    cont_d     = cont_q;
    addr_shift = 1'b0;
    addr_load  = 1'b0;
    byte_step  = 1'b0;
    cfg_we     = 1'b0;
    cfg_byte   = {hi_q, nib};
    if (cs_n) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      phase_d = eff_ph;
      if (take) begin
        case (eff_ph)
          PH_INSTR: begin
            if (cnt_q == CNT_W'(OP_BITS - 1)) begin
              cnt_d = '0;
              case (opcode)
                OPC_FAST:    begin var_d = RV_FAST;    phase_d = PH_ADDR;  end
                OPC_WORD:    begin var_d = RV_WORD;    phase_d = PH_ADDR;  end
                OPC_OCTAL:   begin var_d = RV_OCTAL;   phase_d = PH_ADDR;  end
                OPC_WRAPSET: begin var_d = RV_WRAPSET; phase_d = PH_DUMMY; end
                default:     phase_d = PH_HOLD;
              endcase
            end else begin
              cnt_d = cnt_q + 1'b1;
              op_d  = opcode[OP_BITS-2:0];
            end
          end
          PH_ADDR: begin
            addr_shift = 1'b1;
            if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
              addr_load = 1'b1;
              cnt_d     = '0;
              phase_d   = PH_MODE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_MODE: begin
            if (cnt_q == '0) begin
              hi_d  = nib;
              cnt_d = CNT_W'(1);
            end else begin
              cont_d  = (hi_q[1:0] == 2'b10);
              cnt_d   = '0;
              phase_d = (dlen == '0) ? PH_DATA : PH_DUMMY;
            end
          end
          PH_DUMMY: begin
            if (cnt_q + 1'b1 == dlen) begin
              cnt_d   = '0;
              phase_d = PH_DATA;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (cnt_q == '0) begin
              hi_d  = nib;
              cnt_d = CNT_W'(1);
            end else begin
              cnt_d = '0;
              if (var_q == RV_WRAPSET) begin
                cfg_we  = 1'b1;
                phase_d = PH_HOLD;
              end else begin
                byte_step = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      hi_q    <= '0;
      var_q   <= RV_FAST;
      cont_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      hi_q    <= hi_d;
      var_q   <= var_d;
      cont_q  <= cont_d;
    end
  end

  assign phase_o   = phase_q;
  assign variant_o = var_q;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> phase_q == PH_IDLE); // R1

  AST_DATA_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA && $past(phase_q) != PH_DATA) |->
      ($past(phase_q) == PH_MODE || $past(phase_q) == PH_DUMMY)); // R4

  AST_CONT_SKIP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !cs_n && cont_q && !nib_vld) |=> phase_q == PH_ADDR); // R10

  AST_HOLD_STICKS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD && !cs_n) |=> phase_q == PH_HOLD); // R2

endmodule

// File: rtl/qrs_top.sv
module qrs_top
  import qrs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PAGE_W      = 8,
  parameter int MIN_WRAP_LG = 3,
  parameter int FAST_DUMMY  = 4,
  parameter int WORD_DUMMY  = 2,
  parameter int OCTAL_DUMMY = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              nib_vld,
  input  logic [3:0]        nib,
  output logic [2:0]        phase,
  output logic [ADDR_W-1:0] byte_addr
);

  localparam int ADDR_NIBS = ADDR_W / 4;

  phase_e            phase_w;
  rvar_e             var_w;
  logic              addr_shift, addr_load, byte_step, cfg_we, wrap_en;
  logic [7:0]        cfg_byte;
  logic [PAGE_W-1:0] wrap_mask;

  qrs_ctrl #(
    .OP_BITS(8), .ADDR_NIBS(ADDR_NIBS), .FAST_DUMMY(FAST_DUMMY),
    .WORD_DUMMY(WORD_DUMMY), .OCTAL_DUMMY(OCTAL_DUMMY), .SETUP_DUMMY(6)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .nib_vld(nib_vld), .nib(nib),
    .phase_o(phase_w), .variant_o(var_w), .addr_shift(addr_shift),
    .addr_load(addr_load), .byte_step(byte_step), .cfg_we(cfg_we),
    .cfg_byte(cfg_byte)
  );

  qrs_wrap_cfg #(
    .PAGE_W(PAGE_W), .MIN_WRAP_LG(MIN_WRAP_LG), .SEL_W(2), .SEL_LSB(5), .EN_BIT(4)
  ) u_wrap (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
    .wrap_en(wrap_en), .wrap_mask(wrap_mask)
  );

  qrs_addr_gen #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_LSBS(1), .OCTAL_LSBS(4)
  ) u_addr (
    .clk(clk), .rst(rst), .nib(nib), .addr_shift(addr_shift),
    .addr_load(addr_load), .byte_step(byte_step), .variant(var_w),
    .wrap_en(wrap_en), .wrap_mask(wrap_mask), .byte_addr(byte_addr)
  );

  assign phase = phase_w;

endmodule

// File: tb/tb_qrs_top.sv
module tb_qrs_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        nib_vld = 1'b0;
  logic [3:0]  nib = 4'h0;
  logic [2:0]  phase;
  logic [23:0] byte_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  bit        m_cont = 1'b0;
  int        m_var  = 0;   // 0 fast, 1 word, 2 octal
  bit        m_wen  = 1'b0;
  int        m_wsel = 0;
  logic [23:0] m_addr = '0;

  always #2 clk = ~clk;

  qrs_top dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .nib_vld(nib_vld), .nib(nib),
    .phase(phase), .byte_addr(byte_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] opc(input int v);
    case (v)
      0: return 8'hEB;
      1: return 8'hE7;
      default: return 8'hE3;
    endcase
  endfunction

  function automatic int dummies(input int v);
    case (v)
      0: return 4;
      1: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] align(input int v, input logic [23:0] a);
    if (v == 1) return {a[23:1], 1'b0};
    if (v == 2) return {a[23:4], 4'h0};
    return a;
  endfunction

  function automatic logic [23:0] adv(input logic [23:0] a);
    logic [23:0] len;
    if (m_wen && m_var != 2) begin
      len = 24'd8 << m_wsel;
      return (a & ~(len - 1)) | ((a + 24'd1) & (len - 1));
    end
    return a + 24'd1;
  endfunction

  task automatic strobe(input logic [3:0] n);
    @(negedge clk);
    nib_vld = 1'b1;
    nib = n;
    @(negedge clk);
    nib_vld = 1'b0;
  endtask

  task automatic select_t();
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic deselect_t();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after deselect", phase, 0);
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) strobe({3'($urandom), op[i]});
  endtask

  task automatic read_txn(input int v, input logic [23:0] a, input logic [3:0] mhi, input int nb);
    select_t();
    if (m_cont) begin
      chk("R10 continuous start phase", phase, 2);
    end else begin
      chk("R2 instruction phase", phase, 1);
      m_var = v;
      send_op(opc(v));
      chk("R2 address phase after opcode", phase, 2);
    end
    for (int i = 5; i >= 0; i--) strobe(a[i*4 +: 4]);
    m_addr = align(m_var, a);
    chk("R3/R6 loaded address", byte_addr, m_addr);
    chk("R3 mode phase", phase, 3);
    strobe(mhi);
    strobe(4'($urandom));
    m_cont = (mhi[1:0] == 2'b10);
    chk("R4 after mode byte", phase, (dummies(m_var) != 0) ? 4 : 5);
    for (int i = 0; i < dummies(m_var); i++) strobe(4'($urandom));
    chk("R4 data phase", phase, 5);
    for (int i = 0; i < nb; i++) begin
      strobe(4'($urandom));
      strobe(4'($urandom));
      m_addr = adv(m_addr);
      chk("R5/R8 byte address", byte_addr, m_addr);
    end
    deselect_t();
  endtask

  task automatic wrapset(input bit en, input int sel);
    select_t();
    chk("R2 instruction phase", phase, 1);
    send_op(8'h77);
    chk("R7 setup dummy phase", phase, 4);
    for (int i = 0; i < 6; i++) strobe(4'($urandom));
    chk("R7 wrap byte phase", phase, 5);
    strobe({1'($urandom), 2'(sel), ~en});
    strobe(4'($urandom));
    chk("R7 hold after wrap byte", phase, 6);
    m_wen = en;
    m_wsel = sel;
    deselect_t();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset phase", phase, 0);
    chk("R9 reset address", byte_addr, 0);

    // R5 linear rollover at top of space, wrap off after reset (R9)
    read_txn(0, 24'hFFFFFE, 4'h0, 3);
    // R6 alignment of word and octal reads
    read_txn(1, 24'h00A0C7, 4'h3, 2);
    read_txn(2, 24'h12345F, 4'h0, 2);
    // R8 wrap of 8 bytes near end of page
    wrapset(1'b1, 0);
    read_txn(0, 24'h0000FC, 4'h0, 6);
    read_txn(1, 24'h01023B, 4'h0, 4);
    // R8 octal read ignores wrap
    read_txn(2, 24'h0000F0, 4'h0, 20);
    wrapset(1'b1, 3);
    read_txn(0, 24'h3456FD, 4'h1, 5);
    // R10 continuous mode on, then off
    read_txn(1, 24'h000101, 4'hA, 2);
    read_txn(0, 24'h00ABCD, 4'h2, 3);
    read_txn(0, 24'h00ABCD, 4'h0, 1);
    chk("R10 mode flag cleared", m_cont, 0);
    // R1 strobes while deselected change nothing
    for (int i = 0; i < 5; i++) strobe(4'hF);
    chk("R1 phase while deselected", phase, 0);
    chk("R1 address while deselected", byte_addr, m_addr);
    // R1 abort mid address leaves address alone
    select_t();
    send_op(8'hEB);
    strobe(4'h5);
    strobe(4'h6);
    deselect_t();
    chk("R1 address after abort", byte_addr, m_addr);
    // R2 unknown opcode holds
    select_t();
    send_op(8'h9F);
    chk("R2 hold on unknown opcode", phase, 6);
    strobe(4'h3);
    chk("R2 hold persists", phase, 6);
    deselect_t();
    wrapset(1'b0, 2);

    for (int t = 0; t < 150; t++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (!m_cont && pick == 9) begin
        wrapset(1'($urandom), $urandom_range(0, 3));
      end else begin
        logic [3:0] mh;
        mh = 4'($urandom);
        if ($urandom_range(0, 3) == 0) mh[1:0] = 2'b10;
        read_txn($urandom_range(0, 2), 24'($urandom), mh, $urandom_range(1, 12));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule